// File: doc/BRIEF.md
# Multiplexed-Bus ROM Interface

This block is a 2048-by-8 read-only memory that sits directly on an 8-bit processor bus whose low address byte and data share the same pins. During the address phase the processor places the low address byte on the shared bus and the upper three address bits on separate pins, and raises the address-latch strobe. When the strobe falls, the block captures the full 11-bit address and the levels of its two chip enables. All later selection decisions use these captured values, so the enables may change freely during the data phase.

In the data phase the processor pulls the read strobe low. If the captured enables selected the chip, the block drives the shared bus. With the memory/IO qualifier low it returns the ROM byte at the captured address. With the qualifier high it forwards the byte supplied by the neighbouring I/O port section. At all other times the bus output-enable is low.

ROM contents are computed by a parameterised function, so no memory image is needed. All strobes are sampled on the system clock.

Top module: `mbr_rom_bus`

## Requirements
- R1: While reset is asserted and directly after it, `ad_oe` is 0 and `ad_out` is 0.
- R2: At a clock edge where the strobe `ale` was sampled high at the previous edge and is low now, the block captures the address `{a_hi, ad_in}`, with `a_hi` as bits 10:8 and `ad_in` as bits 7:0.
- R3: The ROM byte at address A is `((A[7:0] * 7) mod 256) XOR (A[10:8] << 5) XOR ROM_SEED`. The default `ROM_SEED` is 0x5A.
- R4: Take a clock edge that samples `rd_n` = 0, `io_m` = 0 and `ale` = 0 while the chip is selected. From that edge until the next one, `ad_oe` = 1 and `ad_out` holds the ROM byte at the captured address.
- R5: Under the same conditions with `io_m` = 1, `ad_out` carries the `io_rdata` value sampled at that edge, with `ad_oe` = 1.
- R6: The chip is selected when, at the capture edge, `ce_n` was 0 and `ce` was 1. Later changes of the live enables have no effect until the next capture.
- R7: If the captured enables did not select the chip, `ad_oe` stays 0 during a read.
- R8: `ad_oe` is 0 after any edge that samples `rd_n` = 1 or `ale` = 1.
- R9: The captured address and select hold until the next falling `ale`. Bus and address-pin activity outside a capture edge does not change the byte returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address-latch strobe; its falling edge captures the address |
| ad_in | input | 8 | Shared bus as seen by the block (low address byte) |
| ad_out | output | 8 | Byte the block drives onto the shared bus |
| ad_oe | output | 1 | Output-enable for `ad_out` onto the shared bus |
| a_hi | input | 3 | Upper address bits 10:8 |
| rd_n | input | 1 | Active-low read strobe |
| io_m | input | 1 | 1 selects I/O port read, 0 selects ROM read |
| ce_n | input | 1 | Active-low chip enable |
| ce | input | 1 | Active-high chip enable |
| io_rdata | input | 8 | Byte from the neighbouring I/O port section |

## Verification
The bench flips both live chip enables during the data phase. A design that decided selection from the live pins would then drive on a deselected cycle or stay silent on a selected one. It repeats a read with no new address strobe while scrambling the bus and upper pins. A design that re-captured outside a falling strobe would return the wrong ROM byte. It also reads at the lowest and highest addresses, so a design that dropped the upper address bits would fail there. Finally it pulls the read strobe low while the address strobe is high, which a design lacking the address-phase guard would answer by driving the bus.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
    parameter int LO_W   = 8;
    parameter int HI_W   = 3;
    parameter int DATA_W = 8;
    parameter int ADDR_W = LO_W + HI_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    // ROM content generator: low byte times seven, upper bits in the top of the byte
    function automatic data_t rom_word(input addr_t a, input data_t seed);
        data_t prod;
        data_t hi;
        prod = data_t'(a[LO_W-1:0]) * data_t'(7);
        hi   = data_t'(a[ADDR_W-1:LO_W]) << (DATA_W - HI_W);
        return prod ^ hi ^ seed;
    endfunction
endpackage

// File: rtl/mbr_addr_latch.sv
module mbr_addr_latch
    import mbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [LO_W-1:0]   ad_lo,
    input  logic [HI_W-1:0]   a_hi,
    input  logic              ce_n,
    input  logic              ce,
    output addr_t             addr,
    output logic              sel
);
    typedef struct packed {
        logic  ale;
        addr_t addr;
        logic  sel;
    } latch_t;

    latch_t st_d, st_q;
    logic   fall;

    always_comb begin
        st_d     = st_q;
        st_d.ale = ale;
        fall     = st_q.ale && !ale;
        if (fall) begin
            st_d.addr = {a_hi, ad_lo};
            st_d.sel  = !ce_n && ce;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr = st_q.addr;
    assign sel  = st_q.sel;

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> addr == $past({a_hi, ad_lo}));

    assert_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> sel == $past(!ce_n && ce));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(addr) && $stable(sel));
endmodule

// File: rtl/mbr_read_ctrl.sv
module mbr_read_ctrl
    import mbr_pkg::*;
#(
    parameter data_t ROM_SEED = 8'h5A
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sel,
    input  addr_t addr,
    input  logic  ale,
    input  logic  rd_n,
    input  logic  io_m,
    input  data_t io_rdata,
    output data_t ad_out,
    output logic  ad_oe
);
    typedef struct packed {
        logic  oe;
        data_t data;
    } rd_t;

    rd_t rs_d, rs_q;

    always_comb begin
        rs_d    = rs_q;
        rs_d.oe = sel && !rd_n && !ale;
        if (rs_d.oe) begin
            rs_d.data = io_m ? io_rdata : rom_word(addr, ROM_SEED);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign ad_out = rs_q.data;
    assign ad_oe  = rs_q.oe;

    assert_oe_needs_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || ale) |=> !ad_oe);

    assert_io_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !rd_n && !ale && io_m) |=> ad_oe && ad_out == $past(io_rdata));
endmodule

// File: rtl/mbr_rom_bus.sv
module mbr_rom_bus
    import mbr_pkg::*;
#(
    parameter data_t ROM_SEED = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [LO_W-1:0]   ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [HI_W-1:0]   a_hi,
    input  logic              rd_n,
    input  logic              io_m,
    input  logic              ce_n,
    input  logic              ce,
    input  logic [DATA_W-1:0] io_rdata
);
    addr_t addr_l;
    logic  sel_l;

    mbr_addr_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .ale   (ale),
        .ad_lo (ad_in),
        .a_hi  (a_hi),
        .ce_n  (ce_n),
        .ce    (ce),
        .addr  (addr_l),
        .sel   (sel_l)
    );

    mbr_read_ctrl #(.ROM_SEED(ROM_SEED)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel_l),
        .addr     (addr_l),
        .ale      (ale),
        .rd_n     (rd_n),
        .io_m     (io_m),
        .io_rdata (io_rdata),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe)
    );

    assert_desel_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_l |=> !ad_oe);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> !ad_oe && ad_out == '0);
endmodule

// File: tb/mbr_rom_bus_bench.sv
module mbr_rom_bus_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ale = 1'b0;
    logic [7:0] ad_in = 8'h00;
    logic [7:0] ad_out;
    logic       ad_oe;
    logic [2:0] a_hi = 3'd0;
    logic       rd_n = 1'b1;
    logic       io_m = 1'b0;
    logic       ce_n = 1'b1;
    logic       ce = 1'b0;
    logic [7:0] io_rdata = 8'h00;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    mbr_rom_bus u_mbr_rom_bus (
        .clk(clk), .rst_n(rst_n), .ale(ale), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .a_hi(a_hi), .rd_n(rd_n), .io_m(io_m), .ce_n(ce_n),
        .ce(ce), .io_rdata(io_rdata)
    );

    function automatic logic [7:0] exp_rom(input logic [10:0] a);
        logic [7:0] p;
        p = a[7:0] * 8'd7;
        return p ^ {a[10:8], 5'b0} ^ 8'h5A;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one address phase then one read; optional flip of the live enables during data phase
    task automatic bus_read(input string tag, input logic [10:0] a, input logic cen,
                            input logic cep, input logic iom, input logic [7:0] iod,
                            input bit flip);
        logic sel;
        logic [7:0] want;
        @(negedge clk);
        ale = 1'b1; ad_in = a[7:0]; a_hi = a[10:8]; ce_n = cen; ce = cep; rd_n = 1'b1;
        @(negedge clk);
        ale = 1'b0;
        @(negedge clk);
        ad_in = 8'($urandom); a_hi = 3'($urandom);
        if (flip) begin ce_n = ~cen; ce = ~cep; end
        io_m = iom; io_rdata = iod; rd_n = 1'b0;
        @(negedge clk);
        sel  = !cen && cep;
        want = iom ? iod : exp_rom(a);
        chk({tag, " oe"}, {7'b0, ad_oe}, {7'b0, sel});
        if (sel) chk({tag, " data"}, ad_out, want);
        rd_n = 1'b1;
        @(negedge clk);
        chk("R8 oe after rd release", {7'b0, ad_oe}, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [10:0] ra;
        logic [7:0]  rd;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", {7'b0, ad_oe}, 8'h00);
        chk("R1 data in reset", ad_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 oe after reset", {7'b0, ad_oe}, 8'h00);

        bus_read("R3 lowest", 11'h000, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
        bus_read("R3 highest", 11'h7FF, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
        bus_read("R2 upper bits", 11'h100, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
        bus_read("R4 mem read", 11'h2C3, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
        bus_read("R5 io read", 11'h155, 1'b0, 1'b1, 1'b1, 8'hC9, 1'b0);
        bus_read("R6 selected then flipped", 11'h4A7, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1);
        bus_read("R6 deselected then flipped", 11'h4A7, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1);
        bus_read("R7 ce_n high", 11'h3F0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
        bus_read("R7 ce low", 11'h3F0, 1'b0, 1'b0, 1'b1, 8'h11, 1'b0);

        // R9: select and address held without a new strobe
        bus_read("R9 setup", 11'h6B2, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
        @(negedge clk);
        ad_in = 8'hFF; a_hi = 3'd1; ce_n = 1'b1; ce = 1'b0; io_m = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        chk("R9 held oe", {7'b0, ad_oe}, 8'h01);
        chk("R9 held data", ad_out, exp_rom(11'h6B2));
        rd_n = 1'b1;

        // R8: read strobe low while address strobe high
        @(negedge clk);
        ale = 1'b1; rd_n = 1'b0;
        @(negedge clk);
        chk("R8 oe with ale high", {7'b0, ad_oe}, 8'h00);
        rd_n = 1'b1; ale = 1'b0;
        @(negedge clk);

        for (int i = 0; i < 60; i++) begin
            ra = 11'($urandom);
            rd = 8'($urandom);
            bus_read("R4 random", ra, 1'($urandom), 1'($urandom), 1'($urandom), rd,
                     bit'($urandom_range(0, 1)));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule